// File: doc/BRIEF.md
# Byte-Buffered Serial Port on APB

This block is a serial port on an APB bus. Its frame format is fixed: one start bit, eight data bits sent least significant bit first, no parity and one stop bit. The bit rate comes from a programmable divider, and one bit period is `divider` PCLK cycles. Each direction holds exactly one byte. The transmitter has a one-byte holding register that feeds a shift register. The receiver has a one-byte capture register that is filled by an oversampling-free mid-bit sampler.

Software drives the port through five mapped words and a bank of read-only identification words. Two of the interrupt sources are latched events: "transmit slot freed" and "byte received". These stay set until software writes 1 to clear them. The two overrun interrupts are not latched. Each one is the live AND of a sticky overrun flag and its enable bit. A combined line is the OR of all four interrupt sources.

Top module: `apb_byte_uart`

## Requirements
- R1: After a synchronous reset, the words at 0x04, 0x08, 0x0C and 0x10 read 0, `txd` is 1 and all five interrupt outputs are 0.
- R2: Control (0x08) keeps only bits [6:0] of a write: bit0 tx enable, bit1 rx enable, bit2 tx irq enable, bit3 rx irq enable, bit4 tx-overrun irq enable, bit5 rx-overrun irq enable, bit6 test bit. Divider (0x10) keeps only bits [19:0].
- R3: Writing the data word (0x00) while status bit0 (tx full) is 0 stores the byte and sets bit0. When tx is enabled and the divider is at least 16, the byte moves to the shifter and bit0 clears. `txd` then sends a low start bit, eight data bits LSB first and a high stop bit, each lasting `divider` cycles. `txd` idles high.
- R4: Writing the data word while status bit0 is 1 sets status bit2 (tx overrun, sticky) and replaces the held byte.
- R5: Interrupt status (0x0C) bit0 and `irq_tx` set when status bit0 falls while control bit2 is 1.
- R6: With rx enabled and a legal divider, the receiver does the following. It detects a falling edge on `rxd` and checks the start bit at mid-period. It samples eight bits at mid-bit and accepts the frame only if the stop bit is high. An accepted byte sets status bit1 (rx full). A bad stop bit, or rx disabled, leaves bit1 at 0.
- R7: Reading the data word returns the received byte in bits [7:0] and clears status bit1.
- R8: A byte accepted while status bit1 is already 1 sets status bit3 (rx overrun, sticky) and overwrites the held byte.
- R9: Interrupt status bit1 and `irq_rx` set when a byte is accepted while control bit3 is 1.
- R10: Interrupt status bit2 equals status bit2 AND control bit4. Interrupt status bit3 equals status bit3 AND control bit5. `irq_txovr` and `irq_rxovr` follow these two bits.
- R11: Writing 1 to status bit2 or bit3 clears that overrun flag. Writes leave status bits 0 and 1 unchanged. Writing 1 to any interrupt status bit clears it, and for bits 2 and 3 this clears the matching overrun flag.
- R12: `irq_any` is 1 exactly when some interrupt status bit is 1.
- R13: The word at 0xFD0 + 4k (k = 0..11) reads ID_BASE + k, with ID_BASE defaulting to 0xA0, and writes to it change nothing. Unmapped words read 0. `pready` is always 1 and `pslverr` is always 0.
- R14: While the divider is below 16, no frame starts: status bit0 stays 1 and `txd` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and bit clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit slot freed (latched) |
| irq_rx | output | 1 | Byte received (latched) |
| irq_txovr | output | 1 | Transmit overrun and enable |
| irq_rxovr | output | 1 | Receive overrun and enable |
| irq_any | output | 1 | OR of all interrupt sources |

## Verification
A register write takes effect on the access-phase clock edge, so the bench reads the effect back in the next APB transfer. Read data is valid during the access phase and is sampled one time unit after the falling edge. The transmit frame begins two edges after the data write. To avoid depending on that exact latency, the bench waits for the start edge, moves to mid-bit, and samples every `divider` cycles after that. A received byte is flagged in the middle of its stop bit, three cycles after the synchroniser. The bench therefore holds the stop bit for a full period and waits a few more cycles before it checks status.

// File: rtl/abu_pkg.sv
package abu_pkg;
  // word offsets (byte address >> 2)
  localparam logic [9:0] WA_DATA   = 10'h000;
  localparam logic [9:0] WA_STATUS = 10'h001;
  localparam logic [9:0] WA_CTRL   = 10'h002;
  localparam logic [9:0] WA_INT    = 10'h003;
  localparam logic [9:0] WA_DIV    = 10'h004;
  localparam logic [9:0] WA_ID0    = 10'h3F4;
  localparam int unsigned ID_COUNT = 12;

  // control bit positions
  localparam int unsigned C_TXEN  = 0;
  localparam int unsigned C_RXEN  = 1;
  localparam int unsigned C_TXIE  = 2;
  localparam int unsigned C_RXIE  = 3;
  localparam int unsigned C_TXOIE = 4;
  localparam int unsigned C_RXOIE = 5;
  localparam int unsigned CTRL_W  = 7;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;
endpackage

// File: rtl/abu_tx.sv
module abu_tx #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned DIV_W     = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_W-1:0]     div,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  output logic                 busy,
  output logic                 txd
);
  localparam int unsigned SH_W  = DATA_BITS + 1;
  localparam int unsigned CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] left;
  logic [DIV_W-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      tick <= '0;
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (!busy) begin
      if (load) begin
        sh   <= {1'b1, data};
        left <= CNT_W'(SH_W);
        tick <= div - 1'b1;
        busy <= 1'b1;
        txd  <= 1'b0;
      end
    end else if (tick != '0) begin
      tick <= tick - 1'b1;
    end else if (left == '0) begin
      busy <= 1'b0;
    end else begin
      txd  <= sh[0];
      sh   <= {1'b1, sh[SH_W-1:1]};
      left <= left - 1'b1;
      tick <= div - 1'b1;
    end
  end

  assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_load_only_idle_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
endmodule

// File: rtl/abu_rx.sv
module abu_rx
  import abu_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned DIV_W     = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [DIV_W-1:0]     div,
  input  logic                 rxd,
  output logic                 valid,
  output logic [DATA_BITS-1:0] byte_out
);
  localparam int unsigned IDX_W = $clog2(DATA_BITS);

  logic             s1, s2, s3;
  rx_state_t        st;
  logic [DIV_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DATA_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= rxd; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      valid    <= 1'b0;
      byte_out <= '0;
    end else begin
      valid <= 1'b0;
      case (st)
        RX_IDLE: if (s3 && !s2) begin
          st  <= RX_START;
          cnt <= div >> 1;
        end
        RX_START: if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!s2) begin
            st  <= RX_BITS;
            cnt <= div - 1'b1;
            idx <= '0;
          end else st <= RX_IDLE;
        RX_BITS: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            sh  <= {s2, sh[DATA_BITS-1:1]};
            cnt <= div - 1'b1;
            idx <= idx + 1'b1;
            if (idx == IDX_W'(DATA_BITS - 1)) st <= RX_STOP;
          end
        RX_STOP: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            st <= RX_IDLE;
            if (s2) begin
              valid    <= 1'b1;
              byte_out <= sh;
            end
          end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assert_accept_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  assert_accept_needs_stop_high_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(s2));
endmodule

// File: rtl/abu_regs.sv
module abu_regs
  import abu_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned DIV_W     = 20,
  parameter int unsigned MIN_DIV   = 16,
  parameter logic [7:0]  ID_BASE   = 8'hA0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [11:0]          paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  input  logic                 tx_busy,
  output logic                 tx_load,
  output logic [DATA_BITS-1:0] tx_data,
  input  logic                 rx_valid,
  input  logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_en,
  output logic [DIV_W-1:0]     div,
  output logic                 irq_tx,
  output logic                 irq_rx,
  output logic                 irq_txovr,
  output logic                 irq_rxovr,
  output logic                 irq_any
);
  logic [CTRL_W-1:0]    ctrl;
  logic [DATA_BITS-1:0] txbuf, rxbuf;
  logic txfull, rxfull, txovr, rxovr, int_tx, int_rx;

  logic       wr, rd;
  logic [9:0] word;
  logic wr_data, wr_stat, wr_ctrl, wr_int, wr_div, rd_data, rx_take, div_ok;
  logic clr_txo, clr_rxo;
  logic [9:0] id_off;
  logic unused_bits;

  assign wr      = psel & penable & pwrite;
  assign rd      = psel & penable & ~pwrite;
  assign word    = paddr[11:2];
  assign wr_data = wr && word == WA_DATA;
  assign wr_stat = wr && word == WA_STATUS;
  assign wr_ctrl = wr && word == WA_CTRL;
  assign wr_int  = wr && word == WA_INT;
  assign wr_div  = wr && word == WA_DIV;
  assign rd_data = rd && word == WA_DATA;
  assign clr_txo = (wr_stat | wr_int) & pwdata[2];
  assign clr_rxo = (wr_stat | wr_int) & pwdata[3];
  assign div_ok  = div >= DIV_W'(MIN_DIV);
  assign tx_load = txfull & ctrl[C_TXEN] & div_ok & ~tx_busy;
  assign tx_data = txbuf;
  assign rx_take = rx_valid & ctrl[C_RXEN];
  assign rx_en   = ctrl[C_RXEN] & div_ok;
  assign id_off  = word - WA_ID0;
  assign unused_bits = ^{pwdata[31:DIV_W], paddr[1:0], id_off[9:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      div    <= '0;
      txbuf  <= '0;
      rxbuf  <= '0;
      txfull <= 1'b0;
      rxfull <= 1'b0;
      txovr  <= 1'b0;
      rxovr  <= 1'b0;
      int_tx <= 1'b0;
      int_rx <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= pwdata[CTRL_W-1:0];
      if (wr_div)  div  <= pwdata[DIV_W-1:0];
      if (wr_data) txbuf <= pwdata[DATA_BITS-1:0];
      txfull <= (txfull & ~tx_load) | wr_data;
      if (wr_data & txfull & ~tx_load) txovr <= 1'b1;
      else if (clr_txo)                txovr <= 1'b0;
      if (rx_take) rxbuf <= rx_byte;
      rxfull <= rx_take | (rxfull & ~rd_data);
      if (rx_take & rxfull & ~rd_data) rxovr <= 1'b1;
      else if (clr_rxo)                rxovr <= 1'b0;
      if (tx_load & ctrl[C_TXIE])      int_tx <= 1'b1;
      else if (wr_int & pwdata[0])     int_tx <= 1'b0;
      if (rx_take & ctrl[C_RXIE])      int_rx <= 1'b1;
      else if (wr_int & pwdata[1])     int_rx <= 1'b0;
    end
  end

  assign irq_tx    = int_tx;
  assign irq_rx    = int_rx;
  assign irq_txovr = txovr & ctrl[C_TXOIE];
  assign irq_rxovr = rxovr & ctrl[C_RXOIE];
  assign irq_any   = irq_tx | irq_rx | irq_txovr | irq_rxovr;

  always_comb begin
    prdata = '0;
    if (word == WA_DATA)        prdata[DATA_BITS-1:0] = rxbuf;
    else if (word == WA_STATUS) prdata[3:0] = {rxovr, txovr, rxfull, txfull};
    else if (word == WA_CTRL)   prdata[CTRL_W-1:0] = ctrl;
    else if (word == WA_INT)    prdata[3:0] = {irq_rxovr, irq_txovr, int_rx, int_tx};
    else if (word == WA_DIV)    prdata[DIV_W-1:0] = div;
    else if (word >= WA_ID0)    prdata[7:0] = ID_BASE + {4'b0, id_off[3:0]};
  end

  assert_txovr_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(txovr) |-> $past(wr_data && txfull));
  assert_inttx_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(int_tx) |-> $past(tx_load && ctrl[C_TXIE]));
  assert_rxfull_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rxfull) |-> $past(rx_valid && ctrl[C_RXEN]));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_valid) |=> !rxfull);
  assert_rxovr_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rxovr) |-> $past(rxfull));
  assert_intrx_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(int_rx) |-> $past(rx_valid && ctrl[C_RXIE]));
  assert_status_ro_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !tx_load && !rx_valid) |=> $stable(txfull) && $stable(rxfull));
  assert_no_start_slow_R14: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> div >= DIV_W'(MIN_DIV));
endmodule

// File: rtl/apb_byte_uart.sv
module apb_byte_uart #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned DIV_W     = 20,
  parameter int unsigned MIN_DIV   = 16,
  parameter logic [7:0]  ID_BASE   = 8'hA0
) (
  input  logic        pclk,
  input  logic        rst,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_txovr,
  output logic        irq_rxovr,
  output logic        irq_any
);
  logic                 tx_busy, tx_load, rx_valid, rx_en;
  logic [DATA_BITS-1:0] tx_data, rx_byte;
  logic [DIV_W-1:0]     div;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  abu_regs #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .ID_BASE(ID_BASE)) u_regs (
    .clk(pclk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .tx_busy(tx_busy), .tx_load(tx_load), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_en(rx_en), .div(div),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr),
    .irq_rxovr(irq_rxovr), .irq_any(irq_any));

  abu_tx #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) u_tx (
    .clk(pclk), .rst(rst), .div(div), .load(tx_load), .data(tx_data),
    .busy(tx_busy), .txd(txd));

  abu_rx #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) u_rx (
    .clk(pclk), .rst(rst), .en(rx_en), .div(div), .rxd(rxd),
    .valid(rx_valid), .byte_out(rx_byte));

  assert_any_follows_sources_R12: assert property (@(posedge pclk) disable iff (rst)
    $rose(irq_any) |-> (irq_tx || irq_rx || irq_txovr || irq_rxovr));
endmodule

// File: tb/apb_byte_uart_test.sv
`timescale 1ns/1ps
module apb_byte_uart_test;
  localparam int DIV = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0, rxd = 1;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, txd, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  apb_byte_uart uut (.pclk(clk), .rst(rst), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .rxd(rxd), .txd(txd), .irq_tx(irq_tx),
    .irq_rx(irq_rx), .irq_txovr(irq_txovr), .irq_rxovr(irq_rxovr), .irq_any(irq_any));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // expected interrupt status from sticky flags and control
  function automatic logic [3:0] exp_int(logic itx, logic irx, logic txo, logic rxo, logic [6:0] c);
    return {rxo & c[5], txo & c[4], irx, itx};
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capture_tx(output logic [7:0] b, output bit ok);
    int t = 0;
    ok = 1; b = '0;
    while (txd !== 1'b0 && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) begin ok = 0; return; end
    idle(DIV/2);
    if (txd !== 1'b0) ok = 0;
    for (int i = 0; i < 8; i++) begin idle(DIV); b[i] = txd; end
    idle(DIV);
    if (txd !== 1'b1) ok = 0;
    idle(DIV);
  endtask

  task automatic send_rx(logic [7:0] b, logic stop);
    @(negedge clk); rxd = 0; idle(DIV);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; idle(DIV); end
    rxd = stop; idle(DIV);
    rxd = 1; idle(DIV + 4);
  endtask

  logic [31:0] r;
  logic [7:0] b, got;
  bit ok;

  initial begin
    void'($urandom(32'd2024));
    idle(3); rst = 0; idle(2);
    // R1 reset
    rd(12'h004, r); chk("R1 status", r, 0);
    rd(12'h008, r); chk("R1 ctrl", r, 0);
    rd(12'h00C, r); chk("R1 int", r, 0);
    rd(12'h010, r); chk("R1 div", r, 0);
    chk("R1 txd/irqs", {txd, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any}, 6'b100000);
    chk("R13 pready/pslverr", {pready, pslverr}, 2'b10);
    // R2 masks
    wr(12'h008, 32'hFFFF_FFFF); rd(12'h008, r); chk("R2 ctrl mask", r, 32'h7F);
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, r); chk("R2 div mask", r, 32'hF_FFFF);
    wr(12'h008, 0); wr(12'h00C, 32'hF); wr(12'h004, 32'hF);
    // R14 slow divider blocks transmission
    wr(12'h010, 8); wr(12'h008, 32'h1); wr(12'h000, 32'h5A);
    idle(60);
    rd(12'h004, r); chk("R14 tx full held", r[0], 1);
    chk("R14 txd idle", txd, 1);
    wr(12'h010, DIV);
    capture_tx(got, ok);
    chk("R3 frame ok", ok, 1); chk("R3 tx byte", got, 8'h5A);
    rd(12'h004, r); chk("R3 tx full cleared", r[0], 0);
    // R4 overrun, R10/R11/R12
    wr(12'h008, 0); wr(12'h000, 32'h11); wr(12'h000, 32'hC3);
    rd(12'h004, r); chk("R4 status", r, 32'h5);
    wr(12'h008, 32'h10);
    rd(12'h00C, r); chk("R10 int txo", r[3:0], exp_int(0, 0, 1, 0, 7'h10));
    chk("R10 irq_txovr", irq_txovr, 1); chk("R12 irq_any", irq_any, 1);
    wr(12'h004, 32'h3); rd(12'h004, r); chk("R11 ro bits kept", r, 32'h5);
    wr(12'h00C, 32'h4); rd(12'h004, r); chk("R11 int w1c clears ovr", r, 32'h1);
    chk("R12 irq_any low", irq_any, 0);
    wr(12'h008, 32'h05);
    capture_tx(got, ok); chk("R4 replaced byte", got, 8'hC3);
    rd(12'h00C, r); chk("R5 int tx", r[3:0], 4'h1); chk("R5 irq_tx", irq_tx, 1);
    wr(12'h00C, 32'h1); chk("R11 int tx cleared", irq_tx, 0);
    // random mix
    for (int n = 0; n < 16; n++) begin
      b = 8'($urandom());
      if ($urandom() % 2 == 0) begin
        wr(12'h008, 32'h05); wr(12'h000, {24'b0, b});
        capture_tx(got, ok);
        chk("R3 random tx", {ok, got}, {1'b1, b});
        chk("R5 random irq_tx", irq_tx, 1);
        wr(12'h00C, 32'h1);
      end else begin
        wr(12'h008, 32'h0A); send_rx(b, 1);
        rd(12'h004, r); chk("R6 rx full", r[1:0], 2'b10);
        rd(12'h00C, r); chk("R9 int rx", r[3:0], exp_int(0, 1, 0, 0, 7'h0A));
        rd(12'h000, r); chk("R7 rx byte", r, {24'b0, b});
        rd(12'h004, r); chk("R7 rx full cleared", r[1], 0);
        wr(12'h00C, 32'h2);
      end
    end
    // R8 rx overrun
    wr(12'h008, 32'h22); send_rx(8'h3C, 1); send_rx(8'hA5, 1);
    rd(12'h004, r); chk("R8 status", r, 32'hA);
    chk("R10 irq_rxovr", irq_rxovr, 1);
    rd(12'h000, r); chk("R8 overwrite", r, 32'hA5);
    wr(12'h004, 32'h8); rd(12'h004, r); chk("R11 status w1c", r, 0);
    // R6 bad stop and disabled rx
    send_rx(8'h77, 0); rd(12'h004, r); chk("R6 bad stop dropped", r[1], 0);
    wr(12'h008, 0); send_rx(8'h66, 1); rd(12'h004, r); chk("R6 rx disabled dropped", r[1], 0);
    // R13 ids
    for (int k = 0; k < 12; k++) begin
      rd(12'hFD0 + 12'(4*k), r); chk("R13 id", r, 32'hA0 + k);
    end
    wr(12'hFE0, 32'h1234); rd(12'hFE0, r); chk("R13 id write ignored", r, 32'hA4);
    rd(12'h020, r); chk("R13 unmapped", r, 0);
    finish_run();
  end
endmodule